// File: doc/BRIEF.md
# DDR Command Decoder with Bank Open-State Tracking

This block watches the command pins of a DDR memory interface. On every rising clock edge it turns the sampled pins into a single command code, names the bank the command targets and reports whether a column access asks for automatic precharge. It also keeps an open/closed flag for each bank, and flags any command that is not allowed in the present bank state.

It is meant for a memory controller's self-check path, a bus monitor or a memory model front end. The block enforces no timing between commands. It does not look at data, strobes or mode register contents. Every output is registered: the result for the pins sampled at one edge appears just after that edge, and the bank flags already include the effect of that command.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When chip select (`cs_n`) is sampled high, the command is reported as NOP (code 0) and no bank flag changes.
- R2: With `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} decode as follows: 000 is MRS (code 1), 011 is ACT (code 4), 101 is RD (code 5), 100 is WR (code 6), 010 is precharge (code 7, or 8 for all banks), 110 is burst stop (code 9) and 111 is NOP (code 0).
- R3: The pattern 001 is a refresh. It is auto refresh (code 2) when both `cke_prev` and `cke_cur` are high, and self-refresh entry (code 3) when `cke_prev` is high and `cke_cur` is low. Any command sampled with `cke_prev` low is reported as NOP.
- R4: `ba` values 0 to 3 select banks A to D, and bank n maps to bit n of `bank_open_o`. `bank_o` equals `ba` for ACT, RD, WR and single-bank precharge, and is 0 for every other command.
- R5: A precharge with `a10` low closes only the addressed bank, and precharging a bank that is already closed is legal. A precharge with `a10` high reports code 8, closes every bank and ignores `ba`.
- R6: `auto_pre_o` equals the sampled `a10` for RD and WR, and is 0 for every other command.
- R7: MRS, auto refresh and self-refresh entry set `illegal_o` when any bank is open. They are legal when all banks are closed.
- R8: RD or WR to a closed bank, or ACT to an open bank, sets `illegal_o`, and all bank flags keep their value.
- R9: A legal ACT opens the bank it addresses. A legal RD or WR with `a10` high closes its bank.
- R10: Outputs change only at the clock edge after the pins are sampled. An asynchronous active-low reset gives cmd NOP, `bank_o` 0, `auto_pre_o` 0, all banks closed, `illegal_o` 0 and `all_idle_o` 1.
- R11: `all_idle_o` is high exactly when no bit of `bank_open_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock enable as sampled at the previous edge |
| cke_cur | input | 1 | Clock enable at the current edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank precharge or auto-precharge key) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W (2) | Target bank of the command |
| auto_pre_o | output | 1 | Auto precharge requested by RD/WR |
| bank_open_o | output | NUM_BANKS (4) | Per-bank open flags after the command |
| all_idle_o | output | 1 | High when every bank is closed |
| illegal_o | output | 1 | Command was illegal in the bank state it met |

## Verification
The bench builds the block with its default of four banks. With this setting the 2-bit bank address covers every bank, and patterns with two banks open at once can be set up before an all-bank precharge. It walks one command sequence in which each illegal case (double ACT, access to a closed bank, MRS/refresh/self-refresh with a bank open) appears right next to its legal twin. This shows that an illegal command leaves the flags unchanged while the same command in the right state updates them.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_AREF = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_WR   = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_PREA = 4'd8,
    CMD_BST  = 4'd9
  } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_cur,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd,
  output logic bank_cmd,
  output logic col_cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke_cur ? CMD_AREF : CMD_SREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign col_cmd  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign bank_cmd = col_cmd || (cmd == CMD_ACT) || (cmd == CMD_PRE);

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic is_open
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         is_open <= 1'b0;
    else if (close_req) is_open <= 1'b0;
    else if (open_req)  is_open <= 1'b1;
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_prev,
  input  logic                 cke_cur,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output cmd_e                 cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic                 auto_pre_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 all_idle_o,
  output logic                 illegal_o
);

  cmd_e                 dec_cmd;
  logic                 dec_bank;
  logic                 dec_col;
  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] set_v;
  logic [NUM_BANKS-1:0] clr_v;
  logic                 any_open;
  logic                 tgt_open;
  logic                 ill;

  sdram_cmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke_cur  (cke_cur),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .cmd      (dec_cmd),
    .bank_cmd (dec_bank),
    .col_cmd  (dec_col)
  );

  always_comb begin
    sel     = '0;
    sel[ba] = 1'b1;
  end

  assign any_open = |open_q;
  assign tgt_open = |(open_q & sel);

  // Legality against the bank state as it stands before this command.
  always_comb begin
    case (dec_cmd)
      CMD_MRS, CMD_AREF, CMD_SREF: ill = any_open;
      CMD_ACT:                     ill = tgt_open;
      CMD_RD, CMD_WR:              ill = !tgt_open;
      default:                     ill = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign set_v[i] = (dec_cmd == CMD_ACT) && !ill && sel[i];
    assign clr_v[i] = (dec_cmd == CMD_PREA)
                    || ((dec_cmd == CMD_PRE) && sel[i])
                    || (dec_col && a10 && !ill && sel[i]);

    sdram_bank_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (set_v[i]),
      .close_req (clr_v[i]),
      .is_open   (open_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o      <= CMD_NOP;
      bank_o     <= '0;
      auto_pre_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      cmd_o      <= dec_cmd;
      bank_o     <= dec_bank ? ba : '0;
      auto_pre_o <= dec_col & a10;
      illegal_o  <= ill;
    end
  end

  assign bank_open_o = open_q;
  assign all_idle_o  = ~any_open;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke_prev,
  input logic                 cs_n,
  input cmd_e                 cmd_o,
  input logic [BA_W-1:0]      bank_o,
  input logic                 auto_pre_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 all_idle_o,
  input logic                 illegal_o
);

  // R1
  cs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (cmd_o == CMD_NOP));

  // R3
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cke_prev) |-> (cmd_o == CMD_NOP));

  // R8
  illegal_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (bank_open_o == $past(bank_open_o)));

  // R5
  prea_closes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PREA) |-> (bank_open_o == '0));

  // R7
  mrs_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o inside {CMD_MRS, CMD_AREF, CMD_SREF}) && !illegal_o) |-> all_idle_o);

  // R9
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_ACT) && !illegal_o) |-> bank_open_o[bank_o]);

  // R9
  autopre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o inside {CMD_RD, CMD_WR}) && auto_pre_o && !illegal_o)
      |-> !bank_open_o[bank_o]);

  // R6
  autopre_only_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (cmd_o inside {CMD_RD, CMD_WR}));

  // R7
  illegal_kinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cmd_o inside {CMD_MRS, CMD_AREF, CMD_SREF, CMD_ACT, CMD_RD, CMD_WR}));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
  import sdram_trk_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke_prev = 1'b1, cke_cur = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  cmd_e       cmd_o;
  logic [1:0] bank_o;
  logic       auto_pre_o;
  logic [3:0] bank_open_o;
  logic       all_idle_o;
  logic       illegal_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_cur(cke_cur),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd_o(cmd_o), .bank_o(bank_o), .auto_pre_o(auto_pre_o),
    .bank_open_o(bank_open_o), .all_idle_o(all_idle_o), .illegal_o(illegal_o)
  );

  // Stimulus {cke_prev,cke_cur,cs_n,ras_n,cas_n,we_n,ba,a10}
  // Expect   {cmd,bank,auto_pre,bank_open,illegal}
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    21'b11_0111_00_0_0000_00_0_0000_0, // R2 nop
    21'b11_0011_00_0_0100_00_0_0001_0, // R9 act bank A
    21'b11_0011_10_0_0100_10_0_0101_0, // R4 act bank C
    21'b11_0011_10_0_0100_10_0_0101_1, // R8 act open bank
    21'b11_0101_01_0_0101_01_0_0101_1, // R8 read closed bank
    21'b11_0101_00_0_0101_00_0_0101_0, // R6 read no auto pre
    21'b11_0100_10_1_0110_10_1_0001_0, // R9 write auto pre closes C
    21'b11_0000_00_0_0001_00_0_0001_1, // R7 mrs with bank open
    21'b11_0001_00_0_0010_00_0_0001_1, // R7 aref with bank open
    21'b11_1011_11_0_0000_00_0_0001_0, // R1 cs high masks act
    21'b11_0010_11_0_0111_11_0_0001_0, // R5 pre closed bank legal
    21'b11_0010_00_0_0111_00_0_0000_0, // R5 pre bank A
    21'b11_0000_00_0_0001_00_0_0000_0, // R7 mrs idle legal
    21'b11_0110_00_0_1001_00_0_0000_0, // R2 burst stop
    21'b11_0011_01_0_0100_01_0_0010_0, // R4 act bank B
    21'b11_0011_11_0_0100_11_0_1010_0, // R4 act bank D
    21'b11_0010_01_1_1000_00_0_0000_0, // R5 precharge all
    21'b11_0001_00_0_0010_00_0_0000_0, // R3 auto refresh
    21'b10_0001_00_0_0011_00_0_0000_0, // R3 self refresh entry
    21'b01_0011_00_0_0000_00_0_0000_0, // R3 cke_prev low masks
    21'b11_0011_01_0_0100_01_0_0010_0, // R9 act bank B
    21'b10_0001_00_0_0011_00_0_0010_1, // R7 sref with bank open
    21'b11_0101_01_1_0101_01_1_0000_0, // R9 read auto pre closes B
    21'b11_0100_10_1_0110_10_1_0000_1  // R6 write closed, flag follows a10
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_state();
    chk("R10 cmd",       int'(cmd_o), 0);
    chk("R10 bank",      int'(bank_o), 0);
    chk("R10 auto_pre",  int'(auto_pre_o), 0);
    chk("R10 bank_open", int'(bank_open_o), 0);
    chk("R10 illegal",   int'(illegal_o), 0);
    chk("R11 all_idle",  int'(all_idle_o), 1);
  endtask

  task automatic drive(input logic [8:0] p);
    {cke_prev, cke_cur, cs_n, ras_n, cas_n, we_n, ba, a10} = p;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    drive(9'b11_1111_00_0);
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20:12]);
      @(posedge clk);
      #1;
      // R10: outputs reflect the pins sampled at the edge just passed
      chk("R2 cmd",        int'(cmd_o),       int'(VEC[i][11:8]));
      chk("R4 bank",       int'(bank_o),      int'(VEC[i][7:6]));
      chk("R6 auto_pre",   int'(auto_pre_o),  int'(VEC[i][5]));
      chk("R8 bank_open",  int'(bank_open_o), int'(VEC[i][4:1]));
      chk("R7 illegal",    int'(illegal_o),   int'(VEC[i][0]));
      chk("R11 all_idle",  int'(all_idle_o),  int'(VEC[i][4:1] == 4'b0000));
      @(negedge clk);
    end

    // R10: outputs hold while pins change between edges
    drive(9'b11_0011_11_0);
    #1;
    chk("R10 no change before edge", int'(bank_open_o), 0);
    @(negedge clk);
    chk("R10 act D after edge", int'(bank_open_o), 4'b1000);
    drive(9'b11_1111_00_0);

    // R10: asynchronous reset clears open state mid-run
    #1 rst_n = 1'b0;
    #1;
    chk_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule